// File: doc/BRIEF.md
# Dual-Clock Dual-Port RAM with Selectable Aspect Ratio

This block is a 2,304-bit memory with one write port and one read port, each running on its own clock. A static mode input picks the organisation: 128 words of 18 bits or 256 words of 9 bits. Both ports always present an 18-bit data bus and an 8-bit address bus. Lines that the chosen organisation does not need are ignored on input and driven to zero on output.

Writes are always synchronous to the write clock, and the write enable acts as a clock enable. A static select sets how the read port works. In registered mode, the read enable acts as a clock enable on an output register. In flow-through mode, the read data follows the read address combinationally while the read enable is high. In both read modes the output holds its last captured value while the read enable is low.

Storage is two 9-bit lanes of 128 rows. In the wide organisation a row holds one word. In the narrow organisation the even word of a row sits in the low lane and the odd word in the high lane. The same contents can therefore be read in either organisation.

Top module: `cfg_dpram`

## Requirements
- R1: After rst_ni is released and while re_i stays low, rdata_o is 0 in both read modes.
- R2: With mode_i set to anything except 2'b01, the memory is 128 words of 18 bits. Address bit 7 is ignored on both ports, and row k is addressed by bits [6:0].
- R3: With mode_i equal to 2'b01, the memory is 256 words of 9 bits. wdata_i[17:9] is ignored, and rdata_o[17:9] reads as zero.
- R4: In the 256x9 organisation, word 2k is bits [8:0] of 18-bit row k and word 2k+1 is bits [17:9] of row k. This mapping is visible when the same contents are read in the other organisation.
- R5: A word is written only on a rising wclk_i edge while we_i is high. With we_i low the memory does not change.
- R6: With async_rd_i low, rdata_o takes the addressed word at the rising rclk_i edge where re_i is high, so data appears one read-clock edge after the address.
- R7: With async_rd_i high and re_i high, rdata_o follows raddr_i combinationally and shows a word written on an earlier write-clock edge.
- R8: With re_i low, rdata_o holds the value captured at the last rising rclk_i edge at which re_i was high. This applies in both read modes.
- R9: Reset does not clear the memory contents. mode_i and async_rd_i change only while rst_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the read output register |
| mode_i | input | 2 | Organisation select, static: 2'b01 selects 256x9, any other value selects 128x18 |
| async_rd_i | input | 1 | Static: 1 selects flow-through reads, 0 selects registered reads |
| we_i | input | 1 | Write enable (clock enable on wclk_i) |
| waddr_i | input | 8 | Write word address |
| wdata_i | input | 18 | Write data |
| re_i | input | 1 | Read enable |
| raddr_i | input | 8 | Read word address |
| rdata_o | output | 18 | Read data |

## Verification
The bench fills the whole array in each organisation with computed patterns and sets the unused address bit and data bits to garbage. A design that decoded address bit 7 in the wide organisation, or stored wdata_i[17:9] in the narrow one, would then read back wrong words. The bench switches organisation without rewriting memory, so swapped lane halves or an off-by-one row index in the narrow mapping show up as mismatches. It drops the read enable and then moves the address in both read modes: an output that kept tracking the address, or that lost its captured value, would fail. A write issued with we_i low and read back in flow-through mode catches a write path that is not gated by the enable.

// File: rtl/cfg_dpram_pkg.sv
package cfg_dpram_pkg;
  typedef enum logic [1:0] {
    ORG_WIDE   = 2'b00,
    ORG_NARROW = 2'b01,
    ORG_RSV_A  = 2'b10,
    ORG_RSV_B  = 2'b11
  } org_e;

  function automatic logic org_is_narrow(logic [1:0] m);
    return m == ORG_NARROW;
  endfunction
endpackage

// File: rtl/dpram_addr_map.sv
module dpram_addr_map #(
  parameter int ROW_W = 7,
  localparam int AW = ROW_W + 1
) (
  input  logic             narrow_i,
  input  logic             en_i,
  input  logic [AW-1:0]    addr_i,
  output logic [ROW_W-1:0] row_o,
  output logic             lane_o,
  output logic [1:0]       lane_en_o
);
  always_comb begin
    if (narrow_i) begin
      row_o  = addr_i[AW-1:1];
      lane_o = addr_i[0];
    end else begin
      row_o  = addr_i[ROW_W-1:0];
      lane_o = 1'b0;
    end
    if (!en_i)         lane_en_o = 2'b00;
    else if (!narrow_i) lane_en_o = 2'b11;
    else               lane_en_o = lane_o ? 2'b10 : 2'b01;
  end
endmodule

// File: rtl/dpram_lane.sv
module dpram_lane #(
  parameter int ROWS = 128,
  parameter int W    = 9,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             wclk_i,
  input  logic             we_i,
  input  logic [ROW_W-1:0] wrow_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [ROW_W-1:0] rrow_i,
  output logic [W-1:0]     rdata_o
);
  logic [W-1:0] mem_q [ROWS];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[wrow_i] <= wdata_i;
  end

  assign rdata_o = mem_q[rrow_i];
endmodule

// File: rtl/dpram_rd_port.sv
module dpram_rd_port #(
  parameter int W = 9,
  localparam int DW = 2 * W
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          async_rd_i,
  input  logic          narrow_i,
  input  logic          re_i,
  input  logic          lane_sel_i,
  input  logic [DW-1:0] row_data_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] flow_d;
  logic [DW-1:0] rdata_q;

  always_comb begin
    if (narrow_i)
      flow_d = {{W{1'b0}}, lane_sel_i ? row_data_i[DW-1:W] : row_data_i[W-1:0]};
    else
      flow_d = row_data_i;
  end

  // same register serves as sync output and async hold
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= flow_d;
  end

  assign rdata_o = (async_rd_i && re_i) ? flow_d : rdata_q;

  AST_RD_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_q)); // R8

  AST_NARROW_TOP_ZERO: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    narrow_i |=> rdata_q[DW-1:W] == '0); // R3
endmodule

// File: rtl/cfg_dpram.sv
module cfg_dpram
  import cfg_dpram_pkg::*;
#(
  parameter int ROWS   = 128,
  parameter int LANE_W = 9,
  localparam int ROW_W = $clog2(ROWS),
  localparam int AW    = ROW_W + 1,
  localparam int DW    = 2 * LANE_W
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          async_rd_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic             narrow;
  logic [ROW_W-1:0] wrow, rrow;
  logic             wlane_unused, rlane;
  logic [1:0]       wlane_en, rlane_en_unused;
  logic [DW-1:0]    row_data;

  assign narrow = org_is_narrow(mode_i);

  dpram_addr_map #(.ROW_W(ROW_W)) u_wmap (
    .narrow_i(narrow), .en_i(we_i), .addr_i(waddr_i),
    .row_o(wrow), .lane_o(wlane_unused), .lane_en_o(wlane_en)
  );

  dpram_addr_map #(.ROW_W(ROW_W)) u_rmap (
    .narrow_i(narrow), .en_i(re_i), .addr_i(raddr_i),
    .row_o(rrow), .lane_o(rlane), .lane_en_o(rlane_en_unused)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [LANE_W-1:0] lane_wdata;
    // narrow words always come in on the low data lines
    assign lane_wdata = narrow ? wdata_i[LANE_W-1:0] : wdata_i[g*LANE_W +: LANE_W];

    dpram_lane #(.ROWS(ROWS), .W(LANE_W)) u_lane (
      .wclk_i(wclk_i), .we_i(wlane_en[g]), .wrow_i(wrow), .wdata_i(lane_wdata),
      .rrow_i(rrow), .rdata_o(row_data[g*LANE_W +: LANE_W])
    );
  end

  dpram_rd_port #(.W(LANE_W)) u_rd (
    .rclk_i(rclk_i), .rst_ni(rst_ni), .async_rd_i(async_rd_i), .narrow_i(narrow),
    .re_i(re_i), .lane_sel_i(rlane), .row_data_i(row_data), .rdata_o(rdata_o)
  );

  AST_WR_GATED: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !we_i |-> wlane_en == 2'b00); // R5

  AST_NARROW_ONE_LANE: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (narrow && we_i) |-> $countones(wlane_en) == 1); // R4

  AST_MODE_STATIC: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $stable(mode_i) && $stable(async_rd_i)); // R9
endmodule

// File: tb/sim_cfg_dpram.sv
module sim_cfg_dpram;
  logic        wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        async_rd = 1'b0, we = 1'b0, re = 1'b0;
  logic [7:0]  waddr = '0, raddr = '0;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;

  int nchk = 0, nfail = 0;
  logic [17:0] model [128];

  always #5 wclk = ~wclk;
  always #6 rclk = ~rclk;

  cfg_dpram u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .mode_i(mode),
    .async_rd_i(async_rd), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .re_i(re), .raddr_i(raddr), .rdata_o(rdata)
  );

  function automatic logic [17:0] pat_w(int a);
    return 18'((a * 2741 + 77) ^ (a << 11));
  endfunction

  function automatic logic [8:0] pat_n(int n);
    return 9'(n * 53 + 19);
  endfunction

  task automatic chk(string tag, logic [17:0] act, logic [17:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] m, logic a);
    rst_ni = 1'b0;
    re = 1'b0; we = 1'b0;
    #3 mode = m; async_rd = a;
    repeat (3) @(posedge rclk);
    @(negedge wclk) rst_ni = 1'b1;
    @(negedge rclk);
  endtask

  task automatic wr(logic [7:0] a, logic [17:0] d);
    @(negedge wclk); we = 1'b1; waddr = a; wdata = d;
    @(negedge wclk); we = 1'b0;
  endtask

  task automatic rd_sync(logic [7:0] a, logic [17:0] exp, string tag);
    @(negedge rclk); re = 1'b1; raddr = a;
    @(negedge rclk); re = 1'b0;
    chk(tag, rdata, exp);
  endtask

  initial begin
    #2ms;
    nfail++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    // wide organisation, registered read
    do_reset(2'b00, 1'b0);
    chk("R1 reset sync", rdata, 18'h0);
    for (int a = 0; a < 128; a++) begin
      model[a] = pat_w(a);
      wr(8'(a) | {a[0], 7'b0}, model[a]); // R2 bit7 garbage
    end
    for (int a = 0; a < 128; a++)
      rd_sync(8'(a) | {~a[0], 7'b0}, model[a], "R2 R6 wide read");

    // R6 latency: data at first edge after address
    @(negedge rclk); re = 1'b1; raddr = 8'd9;
    #1 chk("R6 no flow-through", rdata, model[127]);
    @(negedge rclk); chk("R6 one edge", rdata, model[9]);
    // R8 hold in registered mode
    re = 1'b0; raddr = 8'd40;
    @(negedge rclk); @(negedge rclk);
    chk("R8 hold sync", rdata, model[9]);

    // R5 write with we low
    @(negedge wclk); we = 1'b0; waddr = 8'd5; wdata = ~model[5];
    @(negedge wclk); @(negedge wclk);
    rd_sync(8'd5, model[5], "R5 we low");

    // narrow organisation over existing contents, R9 no clear
    do_reset(2'b01, 1'b0);
    chk("R1 reset narrow", rdata, 18'h0);
    for (int n = 0; n < 256; n++)
      rd_sync(8'(n), {9'h0, n[0] ? model[n/2][17:9] : model[n/2][8:0]}, "R4 R9 narrow view");
    for (int n = 0; n < 256; n++) begin
      wr(8'(n), {9'(n ^ 9'h1a5), pat_n(n)}); // R3 upper garbage
      model[n/2][n[0]*9 +: 9] = pat_n(n);
    end
    for (int n = 0; n < 256; n++)
      rd_sync(8'(n), {9'h0, pat_n(n)}, "R3 narrow read");

    // flow-through, wide
    do_reset(2'b00, 1'b1);
    chk("R1 reset async", rdata, 18'h0);
    for (int k = 0; k < 128; k += 7) begin
      @(negedge rclk); re = 1'b1; raddr = 8'(k);
      #1 chk("R4 R7 wide view of narrow writes", rdata, {pat_n(2*k+1), pat_n(2*k)});
    end
    wr(8'd3, 18'h2bcde);
    model[3] = 18'h2bcde;
    @(negedge rclk); re = 1'b1; raddr = 8'd3;
    #1 chk("R7 flow after write", rdata, 18'h2bcde);
    raddr = 8'd10;
    #1 chk("R7 follows addr", rdata, model[10]);
    @(posedge rclk); @(negedge rclk);
    re = 1'b0; raddr = 8'd20;
    #1 chk("R8 hold async", rdata, model[10]);
    @(negedge rclk);
    chk("R8 hold async later", rdata, model[10]);
    @(negedge wclk); we = 1'b0; waddr = 8'd20; wdata = 18'h0;
    @(negedge wclk);
    @(negedge rclk); re = 1'b1;
    #1 chk("R5 we low async", rdata, model[20]);
    re = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule